// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Transceiver Enable

This block turns bytes into asynchronous serial frames on a single output line. Software writes a byte into a one-entry holding register. The sequencer moves that byte into a frame shifter and clocks it out at a rate set by an external oversampling tick. Each bit lasts a fixed number of ticks. A parity bit, even or odd, can be added after the data bits. An empty flag shows when the holding register can take the next byte, so a second byte can wait while the first one is still on the line.

The block also drives an enable output for an external half-duplex line transceiver. The enable turns on as soon as a byte is written. It stays on for a lead-in of one to two bit times before the start bit, then through the whole frame. It turns off one clock after the stop bit ends. When characters follow each other with no gap, the enable stays on between them. A control input selects the polarity of this output.

An optional clear-to-send handshake can hold back the next character. The sequencer looks at the synchronised clear-to-send level only at the point where a new character would begin. A character that has already started is always sent to the end.

Top module: `uart_flow_tx`

## Requirements
- R1: While reset is asserted and after it is released with no write, `txd` is 1, the enable is inactive and `tx_empty` is 1.
- R2: A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then one high stop bit. Every bit lasts exactly OVS ticks of `tick`.
- R3: When `par_en` is 1, a parity bit follows the data bits. If `par_odd` is 0 it makes the number of ones even; if `par_odd` is 1 it makes the number of ones odd. The parity settings are captured when the character starts.
- R4: `tx_empty` goes to 0 in the clock after a write. It returns to 1 in the same clock in which the start bit of that byte appears on `txd`. A byte written while a frame is in flight is kept and sent after it.
- R5: A write while the enable is inactive turns the enable on in the clock after the write. The start bit follows at least OVS*tick-period and at most 2*OVS*tick-period clocks after that write.
- R6: The enable stays active for the whole frame. It becomes inactive exactly one clock after the last tick interval of the stop bit. Whenever the enable is inactive, `txd` is 1.
- R7: A byte written before the current stop bit ends starts right after that stop bit, with no idle bit time in between. The enable does not drop between the two frames.
- R8: When `de_low` is 0 the enable output `de` is active-high. When `de_low` is 1 it is active-low.
- R9: With `cts_en` at 1, a character starts only if `cts` was 1 two clocks before the start edge (one clock of synchronisation plus the decision edge). While the character is held back, `txd` stays 1, the enable stays active and `tx_empty` stays 0. Once `cts` returns to 1, the character starts on a later tick.
- R10: If `cts` falls after a character has started, that character is still sent in full, including parity and stop.
- R11: With `cts_en` at 0, the level on `cts` has no effect: characters start after the normal lead-in.
- R12: `txd` changes only on a clock edge at which `tick` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| cts_en | input | 1 | 1 enables clear-to-send gating |
| de_low | input | 1 | 1 makes `de` active-low |
| par_en | input | 1 | 1 appends a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| tick | input | 1 | Oversampling tick, one clock wide |
| cts | input | 1 | Clear-to-send, active-high |
| txd | output | 1 | Serial data, idles high |
| de | output | 1 | Transceiver enable |
| tx_empty | output | 1 | Holding register can accept a byte |

## Verification
The hardest state to reach from the ports is a byte waiting in the holding register while the enable is on and the line is idle. This happens only when flow control is on and `cts` was low at the moment a character would have begun. The bench gets there by lowering `cts` before a write, waiting several bit times, checking the line and the empty flag, and then releasing `cts`. Random passes do the same with random hold times. A second hard case is the frame boundary of back-to-back characters. The bench writes the next byte on the clock where the empty flag rises, then checks that the next start bit sits exactly one frame length after the first one.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } uftx_state_e;
endpackage

// File: rtl/uftx_hold.sv
// One-entry holding register between the write port and the frame shifter.
module uftx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (wr_en) data <= wr_data;
         // a write on the same edge as a take keeps the new byte
         if (wr_en)     full <= 1'b1;
         else if (take) full <= 1'b0;
      end
   end
endmodule

// File: rtl/uftx_shifter.sv
// Frame shifter: loads start/data/parity/stop, shifts ones in behind.
module uftx_shifter #(
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              shift,
   output logic              txd
);
   localparam int FRAME_W = DATA_W + 3;

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] frame;

   generate
      if (HAS_PARITY) begin : g_par
         logic pbit;
         assign pbit  = par_en ? ((^din) ^ par_odd) : 1'b1;
         assign frame = {1'b1, pbit, din, 1'b0};
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = par_en ^ par_odd;
         assign frame      = {2'b11, din, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     sreg <= '1;
      else if (load)  sreg <= frame;
      else if (shift) sreg <= {1'b1, sreg[FRAME_W-1:1]};
   end

   assign txd = sreg[0];
endmodule

// File: rtl/uftx_seq.sv
// Character sequencer: lead-in, bit timing, flow-control gate, enable tail.
module uftx_seq
   import uftx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic wr_en,
   input  logic full,
   input  logic cts,
   input  logic cts_en,
   input  logic par_en,
   output logic load,
   output logic shift,
   output logic de_act
);
   localparam int TCW = $clog2(OVS + 1);
   localparam int IW  = $clog2(DATA_W + 3);
   localparam logic [TCW-1:0] TC_LAST = TCW'(OVS - 1);
   localparam logic [TCW-1:0] TC_LEAD = TCW'(OVS);
   localparam logic [IW-1:0]  IX_PAR  = IW'(DATA_W + 2);
   localparam logic [IW-1:0]  IX_NOP  = IW'(DATA_W + 1);

   uftx_state_e    state;
   logic [TCW-1:0] tcnt;
   logic [IW-1:0]  idx;
   logic           par_q;
   logic           cts_q;
   logic           go;
   logic           bit_end;
   logic           lead_done;
   logic           at_last;
   logic           frame_end;

   assign go        = !cts_en || cts_q;
   assign bit_end   = (tcnt == TC_LAST);
   assign lead_done = (tcnt == TC_LEAD);
   assign at_last   = (idx == (par_q ? IX_PAR : IX_NOP));
   assign frame_end = (state == ST_SHIFT) && tick && bit_end && at_last;
   assign load      = tick && go && full &&
                      (((state == ST_LEAD) && lead_done) || frame_end);
   assign shift     = (state == ST_SHIFT) && tick && bit_end;
   assign de_act    = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         idx   <= '0;
         par_q <= 1'b0;
         cts_q <= 1'b0;
      end else begin
         cts_q <= cts;
         if (load) begin
            state <= ST_SHIFT;
            tcnt  <= '0;
            idx   <= '0;
            par_q <= par_en;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (wr_en || full) begin
                     state <= ST_LEAD;
                     tcnt  <= '0;
                  end
               end
               ST_LEAD: begin
                  if (tick && !lead_done) tcnt <= tcnt + 1'b1;
               end
               ST_SHIFT: begin
                  if (tick) begin
                     if (bit_end) begin
                        tcnt <= '0;
                        if (at_last) begin
                           if (full) begin
                              // byte pending but gated: wait at the start point
                              state <= ST_LEAD;
                              tcnt  <= TC_LEAD;
                           end else begin
                              state <= ST_TAIL;
                           end
                        end else begin
                           idx <= idx + 1'b1;
                        end
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               ST_TAIL: begin
                  if (wr_en || full) begin
                     state <= ST_LEAD;
                     tcnt  <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx #(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cts_en,
   input  logic              de_low,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              tick,
   input  logic              cts,
   output logic              txd,
   output logic              de,
   output logic              tx_empty
);
   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("uart_flow_tx: DATA_W must be 5..9");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("uart_flow_tx: OVS must be at least 2");
      end
   endgenerate

   logic              full;
   logic              load;
   logic              shift;
   logic              de_act;
   logic              par_use;
   logic [DATA_W-1:0] hold_data;

   assign par_use = HAS_PARITY && par_en;

   uftx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (load),
      .full    (full),
      .data    (hold_data)
   );

   uftx_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_en  (wr_en),
      .full   (full),
      .cts    (cts),
      .cts_en (cts_en),
      .par_en (par_use),
      .load   (load),
      .shift  (shift),
      .de_act (de_act)
   );

   uftx_shifter #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .din     (hold_data),
      .par_en  (par_use),
      .par_odd (par_odd),
      .shift   (shift),
      .txd     (txd)
   );

   assign de       = de_act ^ de_low;
   assign tx_empty = ~full;
endmodule

// File: rtl/uart_flow_tx_chk.sv
module uart_flow_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic cts,
   input logic cts_en,
   input logic de,
   input logic de_low,
   input logic txd,
   input logic tx_empty
);
   // enable inactive means de equals de_low
   p_idle_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (de == de_low) |-> txd);

   p_release_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((de == de_low) && $past(de != de_low)) |-> $past(txd));

   p_txd_moves_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(tick));

   p_take_starts_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> !txd);

   p_enable_leads_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(de != de_low));

   p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_empty) && $past(cts_en)) |-> $past(cts, 2));
endmodule

bind uart_flow_tx uart_flow_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .cts      (cts),
   .cts_en   (cts_en),
   .de       (de),
   .de_low   (de_low),
   .txd      (txd),
   .tx_empty (tx_empty)
);

// File: tb/sim_uart_flow_tx.sv
module sim_uart_flow_tx;
   localparam int OVS = 16;
   localparam int TP  = 2;
   localparam int BC  = OVS * TP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cts_en = 1'b0;
   logic       de_low = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       tick = 1'b0;
   logic       cts = 1'b1;
   logic       txd;
   logic       de;
   logic       tx_empty;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit in_frame = 1'b0;
   logic [9:0] exp_q[$];

   uart_flow_tx #(.DATA_W(8), .OVS(OVS), .HAS_PARITY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cts_en(cts_en), .de_low(de_low), .par_en(par_en), .par_odd(par_odd),
      .tick(tick), .cts(cts), .txd(txd), .de(de), .tx_empty(tx_empty)
   );

   always #4 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cyc = cyc + 1;
   end

   initial forever begin
      @(negedge clk);
      tick = ((cyc % TP) == 0);
   end

   function automatic bit de_on();
      return bit'(de ^ de_low);
   endfunction

   function automatic logic [10:0] mk_frame(logic [7:0] d, logic pe, logic po);
      return {1'b1, pe ? ((^d) ^ po) : 1'b1, d, 1'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // frame monitor: every cycle of a frame must show the expected bit
   initial begin : mon
      logic [10:0] fr;
      logic [9:0]  ent;
      int nb, e0, bad, pos;
      fr = '1; nb = 10; e0 = 0; bad = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (!in_frame && txd === 1'b0) begin
               in_frame = 1'b1;
               e0 = cyc;
               bad = 0;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R2 unexpected frame", 1, 0);
                  fr = '1; nb = 10;
               end else begin
                  ent = exp_q.pop_front();
                  fr = mk_frame(ent[7:0], ent[8], ent[9]);
                  nb = ent[8] ? 11 : 10;
               end
            end
            if (in_frame) begin
               pos = (cyc - e0) / BC;
               if (txd !== fr[pos] || !de_on()) bad++;
               if (cyc - e0 == nb * BC - 1) begin
                  chk(bad == 0, "R2/R3/R10/R12 frame bits", bad, 0);
                  in_frame = 1'b0;
               end
            end
         end
      end
   end

   task automatic wr(input logic [7:0] d);
      while (!tx_empty) @(negedge clk);
      exp_q.push_back({par_odd, par_en, d});
      wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(!tx_empty, "R4 empty clears after write", int'(tx_empty), 0);
   endtask

   task automatic wait_idle();
      while (de_on() || in_frame || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic measured(input logic [7:0] d, input string tag);
      int tw, t0, t1, nb;
      nb = par_en ? 11 : 10;
      wr(d);
      tw = cyc;
      chk(de_on(), "R5 enable on after write", int'(de_on()), 1);
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      chk((t0 - tw) >= BC && (t0 - tw) <= 2 * BC, {tag, " lead-in"}, t0 - tw, BC);
      chk(tx_empty, "R4 empty at start bit", int'(tx_empty), 1);
      while (de_on()) @(negedge clk);
      t1 = cyc;
      chk(t1 == t0 + nb * BC + 1, "R6 enable release", t1 - t0, nb * BC + 1);
   endtask

   initial begin : main
      int t0, gaps, n;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
      chk(de === 1'b0, "R1 enable in reset", int'(de), 0);
      chk(tx_empty === 1'b1, "R1 empty in reset", int'(tx_empty), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(txd === 1'b1 && de === 1'b0, "R1 idle after reset", int'(txd), 1);

      // basic frames: no parity, even, odd
      measured(8'hA5, "R5");
      wait_idle();
      par_en = 1'b1; par_odd = 1'b0;
      measured(8'h3C, "R3 even");
      wait_idle();
      par_odd = 1'b1;
      measured(8'h01, "R3 odd");
      wait_idle();

      // R8 polarity
      de_low = 1'b1;
      @(negedge clk);
      chk(de === 1'b1, "R8 idle level active-low", int'(de), 1);
      wr(8'h5A);
      repeat (40) @(negedge clk);
      chk(de === 1'b0, "R8 asserted level active-low", int'(de), 0);
      wait_idle();
      de_low = 1'b0;
      @(negedge clk);

      // R7 back-to-back
      par_en = 1'b0;
      wr(8'hF0);
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      wr(8'h0F);
      gaps = 0;
      while (cyc < t0 + 10 * BC) begin
         @(negedge clk);
         if (!de_on()) gaps++;
      end
      chk(gaps == 0, "R7 enable continuous", gaps, 0);
      chk(txd === 1'b0, "R7 next start immediate", int'(txd), 0);
      wait_idle();

      // R11 flow control off: cts ignored
      cts_en = 1'b0; cts = 1'b0;
      measured(8'hC3, "R11");
      wait_idle();
      cts = 1'b1;

      // R9 held character
      cts_en = 1'b1; cts = 1'b0;
      wr(8'h96);
      repeat (3 * BC) @(negedge clk);
      chk(txd === 1'b1, "R9 line idle while held", int'(txd), 1);
      chk(de_on(), "R9 enable on while held", int'(de_on()), 1);
      chk(!tx_empty, "R9 byte still pending", int'(tx_empty), 0);
      cts = 1'b1;
      n = 0;
      while (txd !== 1'b0 && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(txd === 1'b0 && n <= TP + 3, "R9 start after release", n, TP + 3);
      wait_idle();

      // R10 cts drops mid-character
      par_en = 1'b1; par_odd = 1'b0;
      wr(8'h69);
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      repeat (3 * BC) @(negedge clk);
      cts = 1'b0;
      while (de_on()) @(negedge clk);
      chk(cyc == t0 + 11 * BC + 1, "R10 full frame sent", cyc - t0, 11 * BC + 1);
      cts = 1'b1;
      wait_idle();

      // constrained random traffic
      for (int i = 0; i < 24; i++) begin
         if (($urandom % 3) == 0) begin
            wait_idle();
            par_en  = 1'($urandom % 2);
            par_odd = 1'($urandom % 2);
            cts_en  = 1'($urandom % 2);
         end
         cts = (($urandom % 4) != 0);
         repeat ($urandom % 60) @(negedge clk);
         cts = 1'b1;
         wr(8'($urandom));
      end
      wait_idle();
      chk(exp_q.size() == 0, "R2 every byte framed", exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule